// File: doc/BRIEF.md
# Rotating-Priority Bus Arbiter with Timed Preemption

This block is the central arbiter of a shared parallel bus in the PCI style. Up to `N_MASTERS` masters raise active-low request lines. The arbiter answers with at most one active-low grant. It samples the bus frame and initiator-ready lines to tell whether the bus is idle or carrying a transfer. All masters sit in one rotating group. When a granted master starts a transaction, the master that follows it becomes the highest priority and the starter drops to the lowest.

Three mechanisms take a grant away from its holder:
- a higher-priority request that arrives before the holder has started its transfer;
- a preemption timer that fires once another master has waited long enough while the holder owns the bus;
- a watchdog that recovers a grant left unused on an idle bus.

Grant hand-over depends on bus state. On an idle bus there is always at least one empty cycle between grants. On a busy bus one grant can be swapped for another in the same clock.

The preemption enable and the 3-bit time-to-preempt code arrive as plain inputs.

Top module: `rr_bus_arbiter`

## Requirements
- R1: At most one bit of `gnt_n` is low in any cycle. While `rst_n` is low, every bit of `gnt_n` is high.
- R2: When no grant is held and at least one `req_n` bit is low, a grant goes out one clock later to a requesting master. A master whose `req_n` was high never receives a fresh grant.
- R3: The requesting master chosen is the first found when searching upward, with wrap, from the master after the last transaction starter. After reset the search starts at master 0. A starter is recorded on a clock where its grant is held and `frame_n` goes from high to low. A master whose grant expires through R5 is recorded as the last owner as well.
- R4: A held grant is moved away one clock later to the highest-priority requester under R3 when either of these holds:
  - the holder has not yet started a transfer under this grant;
  - the holder has dropped its request while another master requests.
- R5: A grant is removed after 16 consecutive cycles (`IDLE_TIMEOUT`) in which it is held and the bus is idle. The bus is idle when `frame_n` and `irdy_n` are both high.
- R6: When a grant is removed in a cycle where the bus is idle, all grants are high for at least the following cycle. A new grant never appears in the same clock.
- R7: When a grant is removed in a cycle where the bus is busy (`frame_n` or `irdy_n` low), the grant moves in the same clock to the highest-priority other requester under R3.
- R8: `preempt_code` values 0 to 7 select a time-to-preempt of 0, 1, 2, 4, 8, 16, 32 and 64 clocks. Preemption is enabled while `preempt_off` is 0. With preemption enabled, suppose a started holder has seen some other request waiting for more cycles than the time-to-preempt. Its grant is then removed at the next clock.
- R9: While `preempt_off` is 1, a started holder that keeps its request is never removed because others wait. Only R4 or R5 can end its grant.
- R10: The preemption wait count restarts from zero whenever the grant changes or no other master is requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_n | input | N_MASTERS | Active-low request, one per master |
| frame_n | input | 1 | Active-low bus frame |
| irdy_n | input | 1 | Active-low initiator ready |
| preempt_off | input | 1 | 0 enables preemption, 1 disables it |
| preempt_code | input | 3 | Time-to-preempt select |
| gnt_n | output | N_MASTERS | Active-low grant, one per master |

## Verification
A wrong rotation pointer shows up on the next fresh grant: the wrong master's `gnt_n` bit falls one clock after the bus state allows a grant. A miscounting idle or wait counter moves the removal edge of `gnt_n` earlier or later by the amount of the error. A wrong idle/busy decision shows within the removal cycle itself, either as a missing empty cycle or as an extra one. Every such fault appears within one clock of the decision that depends on it. Comparing every cycle of `gnt_n` against a cycle-level model therefore localizes it.

// File: rtl/arb_pkg.sv
package arb_pkg;
   localparam int PRE_CODE_W = 3;
   localparam int PRE_CNT_W  = 7;

   typedef logic [PRE_CNT_W-1:0] pre_cnt_t;

   // code 0 -> 0 clocks, code k>0 -> 2**(k-1) clocks
   function automatic pre_cnt_t pre_cycles(input logic [PRE_CODE_W-1:0] code);
      pre_cnt_t v;
      if (code == '0) v = '0;
      else            v = pre_cnt_t'(1) << (code - 1'b1);
      return v;
   endfunction
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
   parameter int N  = 9,
   parameter int IW = 4
) (
   input  logic [N-1:0]  mask,
   input  logic [IW-1:0] start,
   output logic          found,
   output logic [IW-1:0] idx
);
   logic [N-1:0]  hit;
   logic [IW-1:0] pos [N];

   for (genvar k = 0; k < N; k++) begin : g_scan
      logic [IW:0] sum;
      assign sum    = {1'b0, start} + (IW+1)'(k);
      assign pos[k] = (sum >= (IW+1)'(N)) ? IW'(sum - (IW+1)'(N)) : IW'(sum);
      assign hit[k] = mask[pos[k]];
   end

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int k = 0; k < N; k++) begin
         if (!found && hit[k]) begin
            found = 1'b1;
            idx   = pos[k];
         end
      end
   end
endmodule

// File: rtl/hold_timers.sv
module hold_timers #(
   parameter int CW = 5,
   parameter int WW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          idle_inc,
   input  logic          wait_inc,
   output logic [CW-1:0] idle_cnt,
   output logic [WW-1:0] wait_cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         idle_cnt <= '0;
         wait_cnt <= '0;
      end else begin
         idle_cnt <= idle_inc ? idle_cnt + 1'b1 : '0;
         if (!wait_inc)          wait_cnt <= '0;
         else if (wait_cnt != '1) wait_cnt <= wait_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/rr_bus_arbiter.sv
module rr_bus_arbiter
   import arb_pkg::*;
#(
   parameter int N_MASTERS    = 9,
   parameter int IDLE_TIMEOUT = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_MASTERS-1:0]  req_n,
   input  logic                  frame_n,
   input  logic                  irdy_n,
   input  logic                  preempt_off,
   input  logic [2:0]            preempt_code,
   output logic [N_MASTERS-1:0]  gnt_n
);
   localparam int IW = $clog2(N_MASTERS);
   localparam int CW = $clog2(IDLE_TIMEOUT + 1);

   if (N_MASTERS < 2 || N_MASTERS > 32) begin : g_bad_n
      $error("rr_bus_arbiter: N_MASTERS out of range");
   end
   if (IDLE_TIMEOUT < 2) begin : g_bad_to
      $error("rr_bus_arbiter: IDLE_TIMEOUT too small");
   end

   logic          gnt_v, started, frame_q;
   logic [IW-1:0] gnt_idx, last_owner;
   logic [CW-1:0] idle_cnt;
   pre_cnt_t      wait_cnt;

   logic [N_MASTERS-1:0] req, gmask, others;
   logic                 busy, start_edge, started_now;
   logic                 win_v, alt_v;
   logic [IW-1:0]        win, alt, start_ptr;
   logic                 waiting, hp_move, pre_fire, to_fire, remove;
   logic                 nxt_v, change;
   logic [IW-1:0]        nxt_idx;

   assign req  = ~req_n;
   assign busy = !frame_n || !irdy_n;

   for (genvar i = 0; i < N_MASTERS; i++) begin : g_gnt
      assign gmask[i] = gnt_v && (gnt_idx == IW'(i));
      assign gnt_n[i] = ~gmask[i];
   end

   assign others      = req & ~gmask;
   assign start_ptr   = (last_owner == IW'(N_MASTERS - 1)) ? '0 : last_owner + 1'b1;
   assign start_edge  = gnt_v && !frame_n && frame_q;
   assign started_now = started || start_edge;

   prio_pick #(.N(N_MASTERS), .IW(IW)) u_pick_all (
      .mask(req), .start(start_ptr), .found(win_v), .idx(win));
   prio_pick #(.N(N_MASTERS), .IW(IW)) u_pick_alt (
      .mask(others), .start(start_ptr), .found(alt_v), .idx(alt));

   assign waiting  = gnt_v && started_now && (|others);
   assign hp_move  = gnt_v && win_v && (win != gnt_idx) &&
                     (!started_now || !req[gnt_idx]);
   assign pre_fire = !preempt_off && waiting &&
                     (wait_cnt >= pre_cycles(preempt_code));
   assign to_fire  = gnt_v && !busy && (idle_cnt == CW'(IDLE_TIMEOUT - 1));
   assign remove   = hp_move || pre_fire || to_fire;

   always_comb begin
      nxt_v   = gnt_v;
      nxt_idx = gnt_idx;
      if (!gnt_v) begin
         nxt_v   = win_v;
         nxt_idx = win;
      end else if (remove) begin
         nxt_v   = busy && alt_v;
         nxt_idx = alt;
      end
   end

   assign change = (nxt_v != gnt_v) || (nxt_v && (nxt_idx != gnt_idx));

   hold_timers #(.CW(CW), .WW(PRE_CNT_W)) u_timers (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (change),
      .idle_inc (gnt_v && !busy),
      .wait_inc (waiting),
      .idle_cnt (idle_cnt),
      .wait_cnt (wait_cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_v      <= 1'b0;
         gnt_idx    <= '0;
         started    <= 1'b0;
         frame_q    <= 1'b1;
         last_owner <= IW'(N_MASTERS - 1);
      end else begin
         gnt_v   <= nxt_v;
         gnt_idx <= nxt_v ? nxt_idx : '0;
         started <= change ? 1'b0 : started_now;
         frame_q <= frame_n;
         if (start_edge || to_fire) last_owner <= gnt_idx;
      end
   end
endmodule

// File: rtl/rr_arb_checker.sv
module rr_arb_checker #(
   parameter int N_MASTERS    = 9,
   parameter int IDLE_TIMEOUT = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [N_MASTERS-1:0] req_n,
   input logic                 frame_n,
   input logic                 irdy_n,
   input logic [N_MASTERS-1:0] gnt_n
);
   localparam int KW = $clog2(IDLE_TIMEOUT + 2);

   logic          held, idle;
   logic [KW-1:0] idle_run;
   logic [N_MASTERS-1:0] gnt_q;

   assign held = !(&gnt_n);
   assign idle = frame_n && irdy_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_run <= '0;
         gnt_q    <= '1;
      end else begin
         gnt_q    <= gnt_n;
         if (held && idle && (gnt_n == gnt_q || idle_run == '0))
            idle_run <= (idle_run == '1) ? idle_run : idle_run + 1'b1;
         else
            idle_run <= '0;
      end
   end

   p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~gnt_n));

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (&gnt_n));

   p_fresh_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (&gnt_n) |=> ((~gnt_n & $past(req_n)) == '0));

   p_idle_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (held && idle) |=> ((&gnt_n) || (gnt_n == $past(gnt_n))));

   p_timeout_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      idle_run <= KW'(IDLE_TIMEOUT));
endmodule

bind rr_bus_arbiter rr_arb_checker #(
   .N_MASTERS(N_MASTERS), .IDLE_TIMEOUT(IDLE_TIMEOUT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n),
   .irdy_n(irdy_n), .gnt_n(gnt_n)
);

// File: tb/sim_rr_bus_arbiter.sv
`timescale 1ns/1ps
module sim_rr_bus_arbiter;
   localparam int N  = 9;
   localparam int TO = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req_n = '1;
   logic         frame_n = 1'b1, irdy_n = 1'b1;
   logic         preempt_off = 1'b0;
   logic [2:0]   preempt_code = 3'd0;
   logic [N-1:0] gnt_n;

   int checks = 0, errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   rr_bus_arbiter #(.N_MASTERS(N), .IDLE_TIMEOUT(TO)) u0 (
      .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n),
      .irdy_n(irdy_n), .preempt_off(preempt_off),
      .preempt_code(preempt_code), .gnt_n(gnt_n));

   // ---------------- reference model ----------------
   bit    m_gv, m_started, m_fq;
   int    m_g, m_last, m_idle, m_wait;
   string m_tag = "R1";

   function automatic int pick(input bit [N-1:0] m, input int from, output bit ok);
      ok = 0;
      for (int k = 0; k < N; k++) begin
         int p = (from + k) % N;
         if (m[p]) begin ok = 1; return p; end
      end
      return 0;
   endfunction

   function automatic int tpre(input int c);
      return (c == 0) ? 0 : (1 << (c - 1));
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_gv = 0; m_g = 0; m_started = 0; m_fq = 1;
         m_last = N - 1; m_idle = 0; m_wait = 0; m_tag = "R1";
      end else begin
         bit [N-1:0] rq, oth;
         bit bz, se, sn, wv, av, wt, hp, pf, tf, nv, chg;
         int w, a, ng;
         rq  = ~req_n;
         bz  = !frame_n || !irdy_n;
         oth = rq;
         if (m_gv) oth[m_g] = 1'b0;
         w   = pick(rq,  (m_last + 1) % N, wv);
         a   = pick(oth, (m_last + 1) % N, av);
         se  = m_gv && !frame_n && m_fq;
         sn  = m_started || se;
         wt  = m_gv && sn && (oth != 0);
         hp  = m_gv && wv && (w != m_g) && (!sn || !rq[m_g]);
         pf  = !preempt_off && wt && (m_wait >= tpre(int'(preempt_code)));
         tf  = m_gv && !bz && (m_idle == TO - 1);
         nv = m_gv; ng = m_g;
         if (!m_gv) begin
            nv = wv; ng = w; m_tag = "R2 R3";
         end else if (hp || pf || tf) begin
            nv = bz && av; ng = a;
            if (tf)      m_tag = "R5 R6";
            else if (pf) m_tag = bz ? "R8 R7" : "R8 R6";
            else         m_tag = bz ? "R4 R7" : "R4 R6";
         end else begin
            m_tag = preempt_off ? "R9" : "R10";
         end
         chg = (nv != m_gv) || (nv && ng != m_g);
         if (se || tf) m_last = m_g;
         if (chg) begin
            m_idle = 0; m_wait = 0; m_started = 0;
         end else begin
            m_idle    = (m_gv && !bz) ? m_idle + 1 : 0;
            m_wait    = wt ? ((m_wait < 127) ? m_wait + 1 : 127) : 0;
            m_started = sn;
         end
         m_gv = nv; m_g = nv ? ng : 0; m_fq = frame_n;
      end
   end

   // ---------------- checking ----------------
   function automatic bit [N-1:0] exp_gnt();
      bit [N-1:0] e = '1;
      if (m_gv) e[m_g] = 1'b0;
      return e;
   endfunction

   task automatic check_now(input string scen);
      checks++;
      if (gnt_n !== exp_gnt()) begin
         errors++;
         $display("FAIL %s [%s] gnt_n actual %b expected %b", m_tag, scen, gnt_n, exp_gnt());
      end
      checks++;
      if ($countones(~gnt_n) > 1) begin
         errors++;
         $display("FAIL R1 [%s] gnt_n actual %b expected at most one low", scen, gnt_n);
      end
   endtask

   task automatic cyc(input bit [N-1:0] r, input bit f, input bit i, input string scen);
      req_n = r; frame_n = f; irdy_n = i;
      @(negedge clk);
      check_now(scen);
   endtask

   function automatic bit [N-1:0] rq1(input int m);
      bit [N-1:0] v = '1;
      v[m] = 1'b0;
      return v;
   endfunction

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check_now("R1 reset");
      rst_n = 1'b1;

      // R2 R3: all request, transactions let priority rotate
      for (int t = 0; t < 12; t++) begin
         cyc('0, 1, 1, "R2 R3 grant");
         cyc('0, 0, 1, "R3 start");
         cyc('0, 0, 0, "R3 data");
         cyc('0, 1, 1, "R3 end");
      end
      repeat (3) cyc('1, 1, 1, "R2 quiet");

      // R5: unused grant on idle bus
      preempt_off = 1'b1;
      repeat (40) cyc(rq1(2), 1, 1, "R5 unused");
      repeat (3) cyc('1, 1, 1, "R5 quiet");

      // R8: each preemption code
      preempt_off = 1'b0;
      for (int c = 0; c < 8; c++) begin
         preempt_code = 3'(c);
         cyc(rq1(1), 1, 1, "R8 req");
         cyc(rq1(1), 0, 0, "R8 start");
         repeat (2) cyc(rq1(1), 0, 0, "R8 busy");
         repeat (75) cyc(rq1(1) & rq1(4), 0, 0, "R8 wait");
         repeat (4) cyc('1, 1, 1, "R8 quiet");
      end

      // R9: preemption off
      preempt_off = 1'b1;
      cyc(rq1(6), 1, 1, "R9 req");
      cyc(rq1(6), 0, 0, "R9 start");
      repeat (30) cyc(rq1(6) & rq1(3), 0, 0, "R9 hold");
      repeat (4) cyc('1, 1, 1, "R9 quiet");

      // R10: waiting request that drops restarts the count
      preempt_off = 1'b0; preempt_code = 3'd3;
      cyc(rq1(7), 1, 1, "R10 req");
      cyc(rq1(7), 0, 0, "R10 start");
      for (int t = 0; t < 6; t++) begin
         repeat (3) cyc(rq1(7) & rq1(0), 0, 0, "R10 wait");
         cyc(rq1(7), 0, 0, "R10 drop");
      end
      repeat (8) cyc(rq1(7) & rq1(0), 0, 0, "R10 fire");
      repeat (4) cyc('1, 1, 1, "R10 quiet");

      // R4 R6 R7: higher priority arrivals on idle and busy bus
      cyc(rq1(5), 1, 1, "R4 low");
      repeat (3) cyc(rq1(5) & rq1(m_last == N-1 ? 0 : (m_last + 1) % N), 1, 1, "R4 R6 idle");
      cyc(rq1(8), 1, 1, "R4 next");
      repeat (3) cyc(rq1(8) & rq1(2), 0, 1, "R4 R7 busy");
      repeat (4) cyc('1, 1, 1, "R4 quiet");

      // constrained random
      for (int blk = 0; blk < 40; blk++) begin
         preempt_off  = ($urandom_range(3) == 0);
         preempt_code = 3'($urandom_range(7));
         for (int t = 0; t < 100; t++) begin
            bit [N-1:0] r;
            for (int m = 0; m < N; m++) r[m] = ($urandom_range(2) != 0);
            cyc(r, $urandom_range(2) != 0, $urandom_range(3) != 0, "R1 random");
         end
      end
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            errors++; checks++;
            $display("FAIL R1 watchdog expired");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule